// File: doc/BRIEF.md
# UART Receive Buffer with Ageing Timer

This block sits between a UART deserializer and the CPU. Each received character arrives with a one-cycle valid strobe and three tags: error, frame error and break. The block stores it as a 16-bit word in a 32-deep FIFO. A data-register read strobe removes the oldest word and returns it with a character-valid marker.

A programmable trigger level controls a ready flag, which sets and clears with hysteresis. While the buffer holds data but the ready flag is clear, an ageing timer counts. If no push or pop happens for eight character times (64 bit periods), the timer raises an age flag, so a driver can collect a short tail of data that never reaches the trigger level. Overrun is signalled in two ways: a tag inside the word that fills the last slot, and a sticky flag when a character has to be dropped. The enabled status flags are ORed into a single interrupt line.

Stored word layout: bit 15 is character valid (set only on the read path), bit 14 is error, bit 13 is overrun, bit 12 is frame error, bit 11 is break, bits 10:8 are zero, and the low bits carry the character.

Top module: `uart_rxbuf`

## Requirements
- R1: The buffer holds up to 32 words of 16 bits. Words come out in the order they were accepted, including when a push and a pop fall in the same cycle.
- R2: A character that arrives while 32 words are already stored is discarded and sets the sticky `overrun` flag. `clrOverrun` clears the flag, but a new drop in the same cycle wins.
- R3: A character that is accepted while exactly 31 words are stored, with no pop in that cycle, is stored with bit 14 and bit 13 set. No other word carries bit 13.
- R4: `rxReady` sets when a character arrives and the resulting count is at least `trigLevel`. It clears when a pop leaves the count below `trigLevel`. In every other case it holds its value, including when `trigLevel` changes.
- R5: A read strobe on a non-empty buffer pops the oldest word. In the next cycle `rdData` shows that word with bit 15 set. A read strobe on an empty buffer makes `rdData` zero and changes no flag.
- R6: `rxDataAvail` is high exactly when at least one word is stored, and `rxEmpty` is its inverse.
- R7: The ageing counter advances only while words are stored and `rxReady` is clear. Any arriving character or any pop restarts it from zero.
- R8: After 64×`BIT_CYCLES` consecutive advancing cycles, `ageFlag` sets and stays set. `clrAge` clears it, but a new expiry in the same cycle wins. The counter does not fire again until it is restarted.
- R9: `irq` is the OR of four terms: `ageFlag` AND `ageIrqEn`, `rxReady` AND `readyIrqEn`, `overrun` AND `overrunIrqEn`, and `rxDataAvail` AND `dataIrqEn`.
- R10: Any arriving character with the break tag sets the sticky `breakSeen` flag, even if the character is dropped. Only reset clears it.
- R11: Reset empties the buffer, stops the counter, clears every flag and zeroes `rdData`, so `rxEmpty` is 1.
- R12: When a push and a pop fall in the same cycle, the count is unchanged. When the buffer is full, the arriving character is still dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rxValid | input | 1 | One-cycle strobe for a received character |
| rxData | input | DATA_W | Received character |
| rxErr | input | 1 | Error tag of the character |
| rxFrameErr | input | 1 | Frame error tag of the character |
| rxBreak | input | 1 | Break tag of the character |
| rdEn | input | 1 | Data-register read strobe |
| rdData | output | 16 | Word returned by the last read |
| trigLevel | input | 6 | Trigger level for the ready flag |
| ageIrqEn | input | 1 | Interrupt enable for `ageFlag` |
| readyIrqEn | input | 1 | Interrupt enable for `rxReady` |
| overrunIrqEn | input | 1 | Interrupt enable for `overrun` |
| dataIrqEn | input | 1 | Interrupt enable for `rxDataAvail` |
| clrOverrun | input | 1 | Write-one clear of `overrun` |
| clrAge | input | 1 | Write-one clear of `ageFlag` |
| rxReady | output | 1 | Trigger level reached |
| rxDataAvail | output | 1 | Buffer not empty |
| rxEmpty | output | 1 | Buffer empty |
| overrun | output | 1 | A character was dropped |
| ageFlag | output | 1 | Ageing timeout occurred |
| breakSeen | output | 1 | A break-tagged character arrived |
| irq | output | 1 | Combined interrupt |

## Verification
A character arrival and a CPU pop can fall in the same clock cycle. In that cycle the count, the ready-flag update, the overrun tag and the drop decision all have to agree.

The bench provokes this at three points:
- at a mid-level count,
- at 31 stored words, where no tag may be applied,
- at 32 stored words, where the arrival is dropped while the pop still succeeds.

A behavioural queue model, updated in the same cycle, judges every output each clock. It also confirms that the age counter restarts when either event happens.

// File: rtl/uart_rxbuf_pkg.sv
package uart_rxbuf_pkg;
  localparam int WORD_W    = 16;
  localparam int BIT_VALID = 15;
  localparam int BIT_ERR   = 14;
  localparam int BIT_OVR   = 13;
  localparam int BIT_FRM   = 12;
  localparam int BIT_BRK   = 11;

  // strobes from control to datapath
  typedef struct packed {
    logic push;       // store the incoming character
    logic pop;        // remove head word to the read register
    logic tagOvr;     // incoming character fills the last slot
    logic readEmpty;  // read strobe with nothing stored
  } rxbufStrobes_t;
endpackage

// File: rtl/uart_rxbuf_datapath.sv
module uart_rxbuf_datapath
  import uart_rxbuf_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  rxbufStrobes_t        str,
  input  logic [DATA_W-1:0]    rxData,
  input  logic                 rxErr,
  input  logic                 rxFrameErr,
  input  logic                 rxBreak,
  output logic [CNT_W-1:0]     count,
  output logic [WORD_W-1:0]    rdData
);
  localparam bit POW2 = ((DEPTH & (DEPTH - 1)) == 0);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr, wrNext, rdNext;
  logic [WORD_W-1:0] inWord;

  generate
    if (POW2) begin : g_wrapNatural
      assign wrNext = wrPtr + 1'b1;
      assign rdNext = rdPtr + 1'b1;
    end else begin : g_wrapCompare
      assign wrNext = (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      assign rdNext = (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
    end
  endgenerate

  always_comb begin
    inWord                = '0;
    inWord[DATA_W-1:0]    = rxData;
    inWord[BIT_BRK]       = rxBreak;
    inWord[BIT_FRM]       = rxFrameErr;
    inWord[BIT_OVR]       = str.tagOvr;
    inWord[BIT_ERR]       = rxErr | str.tagOvr;
  end

  always_ff @(posedge clk) begin
    if (str.push) mem[wrPtr] <= inWord;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      count  <= '0;
      rdData <= '0;
    end else begin
      if (str.push) wrPtr <= wrNext;
      if (str.pop)  rdPtr <= rdNext;
      count <= count + CNT_W'(str.push) - CNT_W'(str.pop);
      if (str.pop) begin
        rdData            <= mem[rdPtr];
        rdData[BIT_VALID] <= 1'b1;
      end else if (str.readEmpty) begin
        rdData <= '0;
      end
    end
  end

  p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rstN)
    str.push |-> count != CNT_W'(DEPTH));
  p_no_underflow_r1: assert property (@(posedge clk) disable iff (!rstN)
    str.pop |-> count != '0);
  p_valid_flag_r5: assert property (@(posedge clk) disable iff (!rstN)
    str.pop |=> rdData[BIT_VALID]);
  p_empty_read_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    str.readEmpty |=> rdData == '0);
endmodule

// File: rtl/uart_rxbuf_ager.sv
module uart_rxbuf_ager #(
  parameter int AGE_CYCLES = 256,
  localparam int AW = $clog2(AGE_CYCLES)
) (
  input  logic clk,
  input  logic rstN,
  input  logic run,
  input  logic restart,
  output logic expire
);
  logic [AW-1:0] ageCnt;
  logic          fired;

  assign expire = run && !restart && !fired && (ageCnt == AW'(AGE_CYCLES - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ageCnt <= '0;
      fired  <= 1'b0;
    end else if (restart || !run) begin
      ageCnt <= '0;
      fired  <= 1'b0;
    end else if (!fired) begin
      if (ageCnt == AW'(AGE_CYCLES - 1)) fired <= 1'b1;
      else                               ageCnt <= ageCnt + 1'b1;
    end
  end

  p_age_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    (restart || !run) |=> ageCnt == '0);
  p_single_fire_r8: assert property (@(posedge clk) disable iff (!rstN)
    expire |=> !expire);
endmodule

// File: rtl/uart_rxbuf_ctrl.sv
module uart_rxbuf_ctrl
  import uart_rxbuf_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int TL_W   = 6,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int CMP_W = (CNT_W > TL_W) ? CNT_W : TL_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxValid,
  input  logic             rxBreak,
  input  logic             rdEn,
  input  logic [CNT_W-1:0] count,
  input  logic [TL_W-1:0]  trigLevel,
  input  logic             ageIrqEn,
  input  logic             readyIrqEn,
  input  logic             overrunIrqEn,
  input  logic             dataIrqEn,
  input  logic             clrOverrun,
  input  logic             clrAge,
  input  logic             ageExpire,
  output rxbufStrobes_t    str,
  output logic             ageRun,
  output logic             ageRestart,
  output logic             rxReady,
  output logic             rxDataAvail,
  output logic             rxEmpty,
  output logic             overrun,
  output logic             ageFlag,
  output logic             breakSeen,
  output logic             irq
);
  logic             isFull, isEmpty, dropChar;
  logic [CNT_W-1:0] newCnt;
  logic             atTrig;

  assign isFull   = (count == CNT_W'(DEPTH));
  assign isEmpty  = (count == '0);
  assign dropChar = rxValid && isFull;

  always_comb begin
    str.push      = rxValid && !isFull;
    str.pop       = rdEn && !isEmpty;
    str.readEmpty = rdEn && isEmpty;
    str.tagOvr    = str.push && !str.pop && (count == CNT_W'(DEPTH - 1));
  end

  assign newCnt = count + CNT_W'(str.push) - CNT_W'(str.pop);
  assign atTrig = CMP_W'(newCnt) >= CMP_W'(trigLevel);

  assign ageRun     = !isEmpty && !rxReady;
  assign ageRestart = rxValid || str.pop;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxReady     <= 1'b0;
      rxDataAvail <= 1'b0;
      rxEmpty     <= 1'b1;
      overrun     <= 1'b0;
      ageFlag     <= 1'b0;
      breakSeen   <= 1'b0;
    end else begin
      if (rxValid && atTrig)        rxReady <= 1'b1;
      else if (str.pop && !atTrig)  rxReady <= 1'b0;

      rxDataAvail <= (newCnt != '0);
      rxEmpty     <= (newCnt == '0);

      if (dropChar)        overrun <= 1'b1;
      else if (clrOverrun) overrun <= 1'b0;

      if (ageExpire)   ageFlag <= 1'b1;
      else if (clrAge) ageFlag <= 1'b0;

      if (rxValid && rxBreak) breakSeen <= 1'b1;
    end
  end

  assign irq = (ageFlag && ageIrqEn) || (rxReady && readyIrqEn) ||
               (overrun && overrunIrqEn) || (rxDataAvail && dataIrqEn);

  p_drop_sets_ore_r2: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && isFull) |=> overrun);
  p_ore_sticky_r2: assert property (@(posedge clk) disable iff (!rstN)
    (overrun && !clrOverrun) |=> overrun);
  p_avail_tracks_r6: assert property (@(posedge clk) disable iff (!rstN)
    (rxDataAvail != rxEmpty) && (rxDataAvail == (count != '0)));
  p_ready_sets_r4: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !rdEn && !isFull && (int'(count) + 1 >= int'(trigLevel))) |=> rxReady);
  p_irq_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(ageFlag || rxReady || overrun || rxDataAvail) |-> !irq);
  p_break_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    breakSeen |=> breakSeen);
endmodule

// File: rtl/uart_rxbuf.sv
module uart_rxbuf
  import uart_rxbuf_pkg::*;
#(
  parameter int DEPTH      = 32,
  parameter int DATA_W     = 8,
  parameter int TL_W       = 6,
  parameter int BIT_CYCLES = 4,
  localparam int CNT_W     = $clog2(DEPTH + 1),
  localparam int AGE_CYCLES = 64 * BIT_CYCLES
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxData,
  input  logic              rxErr,
  input  logic              rxFrameErr,
  input  logic              rxBreak,
  input  logic              rdEn,
  output logic [15:0]       rdData,
  input  logic [TL_W-1:0]   trigLevel,
  input  logic              ageIrqEn,
  input  logic              readyIrqEn,
  input  logic              overrunIrqEn,
  input  logic              dataIrqEn,
  input  logic              clrOverrun,
  input  logic              clrAge,
  output logic              rxReady,
  output logic              rxDataAvail,
  output logic              rxEmpty,
  output logic              overrun,
  output logic              ageFlag,
  output logic              breakSeen,
  output logic              irq
);
  rxbufStrobes_t    str;
  logic [CNT_W-1:0] count;
  logic             ageRun, ageRestart, ageExpire;

  uart_rxbuf_datapath #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .str(str), .rxData(rxData), .rxErr(rxErr),
    .rxFrameErr(rxFrameErr), .rxBreak(rxBreak), .count(count), .rdData(rdData)
  );

  uart_rxbuf_ctrl #(.DEPTH(DEPTH), .TL_W(TL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxBreak(rxBreak), .rdEn(rdEn),
    .count(count), .trigLevel(trigLevel), .ageIrqEn(ageIrqEn),
    .readyIrqEn(readyIrqEn), .overrunIrqEn(overrunIrqEn), .dataIrqEn(dataIrqEn),
    .clrOverrun(clrOverrun), .clrAge(clrAge), .ageExpire(ageExpire), .str(str),
    .ageRun(ageRun), .ageRestart(ageRestart), .rxReady(rxReady),
    .rxDataAvail(rxDataAvail), .rxEmpty(rxEmpty), .overrun(overrun),
    .ageFlag(ageFlag), .breakSeen(breakSeen), .irq(irq)
  );

  uart_rxbuf_ager #(.AGE_CYCLES(AGE_CYCLES)) u_age (
    .clk(clk), .rstN(rstN), .run(ageRun), .restart(ageRestart), .expire(ageExpire)
  );

  p_tag_only_full_r3: assert property (@(posedge clk) disable iff (!rstN)
    (str.tagOvr && str.pop) |-> 1'b0);
endmodule

// File: tb/sim_uart_rxbuf.sv
module sim_uart_rxbuf;
  localparam int BITC  = 2;
  localparam int AGE   = 64 * BITC;
  localparam int DEPTH = 32;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN = 1'b0;
  logic rxValid = 0, rxErr = 0, rxFrameErr = 0, rxBreak = 0, rdEn = 0;
  logic [7:0] rxData = '0;
  logic [5:0] trigLevel = '0;
  logic ageIrqEn = 0, readyIrqEn = 0, overrunIrqEn = 0, dataIrqEn = 0;
  logic clrOverrun = 0, clrAge = 0;
  logic [15:0] rdData;
  logic rxReady, rxDataAvail, rxEmpty, overrun, ageFlag, breakSeen, irq;

  uart_rxbuf #(.BIT_CYCLES(BITC)) u0 (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxData(rxData), .rxErr(rxErr),
    .rxFrameErr(rxFrameErr), .rxBreak(rxBreak), .rdEn(rdEn), .rdData(rdData),
    .trigLevel(trigLevel), .ageIrqEn(ageIrqEn), .readyIrqEn(readyIrqEn),
    .overrunIrqEn(overrunIrqEn), .dataIrqEn(dataIrqEn), .clrOverrun(clrOverrun),
    .clrAge(clrAge), .rxReady(rxReady), .rxDataAvail(rxDataAvail),
    .rxEmpty(rxEmpty), .overrun(overrun), .ageFlag(ageFlag),
    .breakSeen(breakSeen), .irq(irq)
  );

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;
  string phase = "R11";

  // behavioural reference
  logic [15:0] q[$];
  logic [15:0] mRd = '0;
  bit mRrdy = 0, mOre = 0, mAg = 0, mBrk = 0, mFired = 0;
  int mT = 0;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s [%s] %s actual=%0h expected=%0h t=%0t", req, phase, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (rstN) begin
      int c, n;
      bit pop, push, runOld, expire;
      logic [15:0] w;
      c = q.size();
      pop = rdEn && c > 0;
      push = rxValid && c < DEPTH;
      runOld = (c != 0) && !mRrdy;
      if (rdEn) mRd = pop ? (q.pop_front() | 16'h8000) : 16'h0000;
      if (push) begin
        w = {1'b0, rxErr, 1'b0, rxFrameErr, rxBreak, 3'b000, rxData};
        if (c == DEPTH - 1 && !pop) w = w | 16'h6000;
        q.push_back(w);
      end
      if (rxValid && c == DEPTH) mOre = 1;
      else if (clrOverrun) mOre = 0;
      if (rxValid && rxBreak) mBrk = 1;
      n = q.size();
      if (rxValid && n >= int'(trigLevel)) mRrdy = 1;
      else if (pop && n < int'(trigLevel)) mRrdy = 0;
      expire = 0;
      if (rxValid || pop || !runOld) begin mT = 0; mFired = 0; end
      else if (!mFired) begin
        if (mT == AGE - 1) begin expire = 1; mFired = 1; end
        else mT++;
      end
      if (expire) mAg = 1;
      else if (clrAge) mAg = 0;
    end
  end

  always @(negedge clk) begin
    if (rstN && !done) begin
      bit mAvail, mIrq;
      mAvail = q.size() != 0;
      mIrq = (mAg && ageIrqEn) || (mRrdy && readyIrqEn) || (mOre && overrunIrqEn) || (mAvail && dataIrqEn);
      chk("R1 R3 R5", "rdData", rdData, mRd);
      chk("R4", "rxReady", rxReady, mRrdy);
      chk("R6", "rxDataAvail", rxDataAvail, mAvail);
      chk("R6", "rxEmpty", rxEmpty, !mAvail);
      chk("R2", "overrun", overrun, mOre);
      chk("R7 R8", "ageFlag", ageFlag, mAg);
      chk("R10", "breakSeen", breakSeen, mBrk);
      chk("R9", "irq", irq, mIrq);
    end
  end

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic setChar(logic [7:0] d, bit e, bit f, bit b);
    rxValid = 1; rxData = d; rxErr = e; rxFrameErr = f; rxBreak = b;
  endtask

  task automatic pushChar(logic [7:0] d, bit e = 0, bit f = 0, bit b = 0);
    setChar(d, e, f, b); tick(); rxValid = 0; rxErr = 0; rxFrameErr = 0; rxBreak = 0;
  endtask

  task automatic readOne();
    rdEn = 1; tick(); rdEn = 0;
  endtask

  task automatic pushPop(logic [7:0] d);
    setChar(d, 0, 0, 0); rdEn = 1; tick(); rxValid = 0; rdEn = 0;
  endtask

  task automatic drain();
    for (int i = 0; i < DEPTH + 2; i++) readOne();
  endtask

  task automatic finish();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      errors++; checks++;
      $display("FAIL watchdog expired, actual=hung expected=done");
      finish();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1;
    @(negedge clk);
    // R11 explicit reset state
    chk("R11", "rdData", rdData, 0);
    chk("R11", "rxEmpty", rxEmpty, 1);
    chk("R11", "flags", {rxReady, rxDataAvail, overrun, ageFlag, breakSeen, irq}, 0);
    tick();
    ageIrqEn = 1; readyIrqEn = 1; overrunIrqEn = 1; dataIrqEn = 1;

    phase = "R1 R5"; trigLevel = 1;
    for (int i = 0; i < 5; i++) pushChar(8'h30 + 8'(i));
    for (int i = 0; i < 6; i++) readOne();
    idle(3);

    phase = "R7 R8"; trigLevel = 8; readyIrqEn = 0; dataIrqEn = 0;
    for (int i = 0; i < 3; i++) pushChar(8'hA0 + 8'(i));
    idle(AGE + 10);
    clrAge = 1; tick(); clrAge = 0;
    idle(AGE / 2); pushChar(8'hA5); idle(AGE / 2 + 4);
    readOne(); idle(AGE + 3);
    clrAge = 1; tick(); clrAge = 0;
    drain();

    phase = "R2 R3"; trigLevel = 40; dataIrqEn = 1;
    for (int i = 0; i < DEPTH + 2; i++) pushChar(8'(i));
    idle(AGE + 5);
    pushPop(8'hEE);
    overrunIrqEn = 0; idle(2); overrunIrqEn = 1;
    clrOverrun = 1; tick(); clrOverrun = 0;
    drain();

    phase = "R12"; trigLevel = 4;
    for (int i = 0; i < 30; i++) pushChar(8'h40 + 8'(i));
    pushPop(8'h80);
    pushChar(8'h81);
    pushPop(8'h82);
    pushChar(8'h83);
    pushPop(8'h84);
    pushChar(8'h85);
    drain();

    phase = "R10"; trigLevel = 1;
    pushChar(8'h11, 0, 1, 0);
    pushChar(8'h00, 1, 1, 1);
    readOne(); readOne(); readOne();

    phase = "R4"; trigLevel = 3;
    pushChar(8'h21); pushChar(8'h22); pushChar(8'h23);
    trigLevel = 5; idle(2);
    pushChar(8'h24);
    readOne(); readOne();
    trigLevel = 0;
    pushChar(8'h25); drain();
    idle(2);

    phase = "R9"; ageIrqEn = 0; readyIrqEn = 0; overrunIrqEn = 0; dataIrqEn = 0;
    idle(2); readyIrqEn = 1; idle(2); readyIrqEn = 0; dataIrqEn = 1; idle(2);
    trigLevel = 10; dataIrqEn = 0; ageIrqEn = 1;
    pushChar(8'h99); idle(AGE + 4);
    ageIrqEn = 0; idle(2);
    drain();

    finish();
  end
endmodule